// File: doc/BRIEF.md
# Host Bus Access Sequencer

This block turns word-wide requests from a simple host port into correctly timed cycles on the asynchronous 16-bit bus of a USB peripheral controller. Each request carries a 32-bit address, a direction and 16 bits of write data. The top byte of the address selects one of two windows. The register window produces a programmed-I/O cycle with chip select asserted. The data window produces a DMA cycle with the DMA acknowledge asserted and chip select held off. Any other address is answered at once with an error and never reaches the bus. The device register address comes from host address bits [9:2], so each host word lands on one 16-bit device register.

The device needs a minimum spacing between the starts of successive cycles. Two cycles that reach the same target may be 50 ns apart. When a write is involved and the target changes, the spacing must be 91 ns. The block remembers the previous cycle and holds the next request stalled, with ready low, until that spacing has passed. Every nanosecond figure is turned into clock cycles from a clock-period parameter, rounding up.

A wake-up request makes the block issue a register read, with chip select and read strobe asserted together, to bring the device out of suspend. It then blocks all traffic for a settling interval of at least 2 ms and shows this on a busy output.

Top module: `hbus_access_seq`

## Requirements
- R1: An address whose bits [31:24] equal 0x00 produces a programmed-I/O cycle. bus_cs_n is low and bus_dack_n is high for the whole strobe, and bus_addr equals address bits [9:2].
- R2: An address whose bits [31:24] equal 0x02 produces a DMA cycle. bus_dack_n is low and bus_cs_n is high for the whole strobe, and bus_cs_n and bus_dack_n are never low together.
- R3: Any other address gets a single cycle with req_ready, rsp_valid and rsp_err all high. No strobe is driven, and the remembered previous access is left unchanged.
- R4: An accepted request drives bus_rd_n (read) or bus_wr_n (write) low for ceil(STROBE_PS/CLK_PS) cycles, with bus_wdata equal to req_wdata on writes. The next cycle has req_ready and rsp_valid high for exactly one cycle, and rsp_rdata holds bus_rdata as sampled in the last strobe cycle. bus_rd_n and bus_wr_n are never low together.
- R5: Two cycles to the same target, meaning the same window and the same bits [9:2], start at least ceil(SAME_PS/CLK_PS) cycles apart. This applies to reads and writes alike.
- R6: When either of two successive cycles is a write and their targets differ, their starts are at least ceil(DIFF_PS/CLK_PS) cycles apart.
- R7: Two successive reads to different targets need only the R5 spacing. With no constraint, a cycle starts in the cycle after the request is first seen in idle, which gives a natural start-to-start pace of strobe length plus 2 cycles.
- R8: The first access after reset has no spacing constraint. Its strobe starts one cycle after the request is presented.
- R9: A wake_req seen in idle drives bus_cs_n and bus_rd_n low together, with bus_wr_n high and bus_addr equal to WAKE_REG, for the strobe length. busy goes high with that strobe and stays high for the strobe length plus ceil(SETTLE_PS/CLK_PS) cycles.
- R10: While busy is high, no strobe other than the wake-up read appears and req_ready stays low. A request held during that time starts in the cycle after busy falls.
- R11: During and right after reset, all four strobes are high and req_ready, rsp_valid and busy are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present; held until req_ready |
| req_addr | input | 32 | Host byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | One-cycle completion of the current request |
| rsp_valid | output | 1 | Response valid, same cycle as req_ready |
| rsp_err | output | 1 | Address outside both windows |
| rsp_rdata | output | 16 | Read data |
| wake_req | input | 1 | Start the wake-up procedure; held until busy rises |
| busy | output | 1 | Wake-up read and settling in progress |
| bus_cs_n | output | 1 | Device chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_dack_n | output | 1 | DMA acknowledge, active low |
| bus_addr | output | 8 | Device register address |
| bus_wdata | output | 16 | Data driven toward the device |
| bus_rdata | input | 16 | Data returned by the device |

## Verification
The bench builds the block with a 10 ns clock and a 20 ns strobe. The strobe then lasts 2 cycles, the natural pace is 4 cycles, the 50 ns rule needs 5 and the 91 ns rule needs 10, so both spacing rules show up as real stalls of different length. The settling time is set to 3 us (300 cycles) instead of 2 ms. This puts the end of the wake-up hold, and the release of a request stalled behind it, within a short run while still exercising the same counter path.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PIO  = 2'd1,
    TGT_DMA  = 2'd2
  } tgt_e;

  typedef struct packed {
    logic       dma;
    logic [7:0] reg_addr;
  } key_t;

  function automatic int ceil_cyc(longint dur_ps, longint clk_ps);
    return int'((dur_ps + clk_ps - 64'sd1) / clk_ps);
  endfunction

endpackage

// File: rtl/hbs_decode.sv
module hbs_decode
  import hbs_pkg::*;
#(
  parameter logic [7:0] PIO_PAGE = 8'h00,
  parameter logic [7:0] DMA_PAGE = 8'h02
) (
  input  logic [31:0] addr,
  output tgt_e        tgt,
  output logic [7:0]  reg_addr
);

  logic unused_bits;

  assign unused_bits = ^{addr[23:10], addr[1:0]};
  assign reg_addr    = addr[9:2];

  always_comb begin
    if (addr[31:24] == PIO_PAGE)      tgt = TGT_PIO;
    else if (addr[31:24] == DMA_PAGE) tgt = TGT_DMA;
    else                              tgt = TGT_NONE;
  end

endmodule

// File: rtl/hbs_countdown.sv
module hbs_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/hbs_spacing.sv
module hbs_spacing
  import hbs_pkg::*;
#(
  parameter int SAME_CYC = 5,
  parameter int DIFF_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic go_write,
  input  key_t go_key,
  input  logic q_write,
  input  key_t q_key,
  output logic clear
);

  localparam int HI_CYC = (DIFF_CYC > SAME_CYC) ? DIFF_CYC : SAME_CYC;
  localparam int CW     = $clog2(HI_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(HI_CYC);
  localparam logic [CW-1:0] SAME_M1 = CW'((SAME_CYC > 0) ? SAME_CYC - 1 : 0);
  localparam logic [CW-1:0] DIFF_M1 = CW'((DIFF_CYC > 0) ? DIFF_CYC - 1 : 0);

  logic          have_q;
  logic          lw_q;
  key_t          lk_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          wide;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (go) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      lw_q   <= 1'b0;
      lk_q   <= '0;
    end else if (go) begin
      have_q <= 1'b1;
      lw_q   <= go_write;
      lk_q   <= go_key;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_MAX;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign wide  = (lw_q || q_write) && (q_key != lk_q);
  assign clear = !have_q || (cnt_q >= (wide ? DIFF_M1 : SAME_M1));

endmodule

// File: rtl/hbus_access_seq.sv
module hbus_access_seq
  import hbs_pkg::*;
#(
  parameter longint     CLK_PS    = 10000,
  parameter longint     STROBE_PS = 20000,
  parameter longint     SAME_PS   = 50000,
  parameter longint     DIFF_PS   = 91000,
  parameter longint     SETTLE_PS = 2000000000,
  parameter logic [7:0] WAKE_REG  = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [15:0] req_wdata,
  output logic        req_ready,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [15:0] rsp_rdata,
  input  logic        wake_req,
  output logic        busy,
  output logic        bus_cs_n,
  output logic        bus_rd_n,
  output logic        bus_wr_n,
  output logic        bus_dack_n,
  output logic [7:0]  bus_addr,
  output logic [15:0] bus_wdata,
  input  logic [15:0] bus_rdata
);

  localparam int STRB_RAW   = ceil_cyc(STROBE_PS, CLK_PS);
  localparam int STRB_CYC   = (STRB_RAW < 1) ? 1 : STRB_RAW;
  localparam int SAME_CYC   = ceil_cyc(SAME_PS, CLK_PS);
  localparam int DIFF_CYC   = ceil_cyc(DIFF_PS, CLK_PS);
  localparam int SETL_RAW   = ceil_cyc(SETTLE_PS, CLK_PS);
  localparam int SETTLE_CYC = (SETL_RAW < 1) ? 1 : SETL_RAW;
  localparam int SW         = $clog2(STRB_CYC + 1);
  localparam int LW         = $clog2(SETTLE_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_XFER   = 3'd1,
    ST_RESP   = 3'd2,
    ST_ERR    = 3'd3,
    ST_WAKE   = 3'd4,
    ST_SETTLE = 3'd5
  } state_e;

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  state_e      state_q, state_d;
  logic        cur_dma_q, cur_dma_d;
  logic        cur_wr_q, cur_wr_d;
  logic [7:0]  cur_addr_q, cur_addr_d;
  logic [15:0] cur_wdata_q, cur_wdata_d;
  logic [15:0] rdata_q, rdata_d;
  logic        lat_en;

  tgt_e        tgt;
  logic [7:0]  dec_reg;
  key_t        q_key, go_key;
  logic        sp_go, sp_go_wr, sp_clear;
  logic        st_load, st_dec, st_zero;
  logic        sl_load, sl_dec, sl_zero;

  hbs_decode u_decode (
    .addr     (req_addr),
    .tgt      (tgt),
    .reg_addr (dec_reg)
  );

  assign q_key = {(tgt == TGT_DMA), dec_reg};

  hbs_spacing #(
    .SAME_CYC (SAME_CYC),
    .DIFF_CYC (DIFF_CYC)
  ) u_spacing (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .go       (sp_go),
    .go_write (sp_go_wr),
    .go_key   (go_key),
    .q_write  (req_write),
    .q_key    (q_key),
    .clear    (sp_clear)
  );

  hbs_countdown #(.W(SW)) u_strobe_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (st_load),
    .load_val (SW'(STRB_CYC - 1)),
    .dec      (st_dec),
    .zero     (st_zero)
  );

  hbs_countdown #(.W(LW)) u_settle_tmr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (sl_load),
    .load_val (LW'(SETTLE_CYC - 1)),
    .dec      (sl_dec),
    .zero     (sl_zero)
  );

  assign st_dec = (state_q == ST_XFER) || (state_q == ST_WAKE);
  assign sl_dec = (state_q == ST_SETTLE);

  always_comb begin
    state_d     = state_q;
    cur_dma_d   = cur_dma_q;
    cur_wr_d    = cur_wr_q;
    cur_addr_d  = cur_addr_q;
    cur_wdata_d = cur_wdata_q;
    rdata_d     = rdata_q;
    lat_en      = 1'b0;
    st_load     = 1'b0;
    sl_load     = 1'b0;
    sp_go       = 1'b0;
    sp_go_wr    = req_write;
    go_key      = q_key;
    unique case (state_q)
      ST_IDLE: begin
        if (wake_req) begin
          state_d    = ST_WAKE;
          st_load    = 1'b1;
          sp_go      = 1'b1;
          sp_go_wr   = 1'b0;
          go_key     = {1'b0, WAKE_REG};
          lat_en     = 1'b1;
          cur_dma_d  = 1'b0;
          cur_wr_d   = 1'b0;
          cur_addr_d = WAKE_REG;
        end else if (req_valid) begin
          if (tgt == TGT_NONE) begin
            state_d = ST_ERR;
          end else if (sp_clear) begin
            state_d     = ST_XFER;
            st_load     = 1'b1;
            sp_go       = 1'b1;
            lat_en      = 1'b1;
            cur_dma_d   = (tgt == TGT_DMA);
            cur_wr_d    = req_write;
            cur_addr_d  = dec_reg;
            cur_wdata_d = req_wdata;
          end
        end
      end
      ST_XFER: begin
        if (st_zero) begin
          state_d = ST_RESP;
          if (!cur_wr_q) rdata_d = bus_rdata;
        end
      end
      ST_RESP, ST_ERR: state_d = ST_IDLE;
      ST_WAKE: begin
        if (st_zero) begin
          state_d = ST_SETTLE;
          sl_load = 1'b1;
        end
      end
      ST_SETTLE: if (sl_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      rdata_q <= rdata_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      cur_dma_q   <= 1'b0;
      cur_wr_q    <= 1'b0;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
    end else if (lat_en) begin
      cur_dma_q   <= cur_dma_d;
      cur_wr_q    <= cur_wr_d;
      cur_addr_q  <= cur_addr_d;
      cur_wdata_q <= cur_wdata_d;
    end
  end

  logic in_xfer, in_wake;
  assign in_xfer = (state_q == ST_XFER);
  assign in_wake = (state_q == ST_WAKE);

  assign bus_cs_n   = !((in_xfer && !cur_dma_q) || in_wake);
  assign bus_dack_n = !(in_xfer && cur_dma_q);
  assign bus_rd_n   = !((in_xfer && !cur_wr_q) || in_wake);
  assign bus_wr_n   = !(in_xfer && cur_wr_q);
  assign bus_addr   = cur_addr_q;
  assign bus_wdata  = cur_wdata_q;

  assign req_ready = (state_q == ST_RESP) || (state_q == ST_ERR);
  assign rsp_valid = req_ready;
  assign rsp_err   = (state_q == ST_ERR);
  assign rsp_rdata = rdata_q;
  assign busy      = in_wake || (state_q == ST_SETTLE);

  // R2
  cs_dack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(!bus_cs_n && !bus_dack_n));

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(!bus_rd_n && !bus_wr_n));

  // R4
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_ready |=> !req_ready);

  // R3
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_err |-> (bus_cs_n && bus_dack_n && bus_rd_n && bus_wr_n));

  // R9
  wake_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && !bus_rd_n) |-> (!bus_cs_n && bus_wr_n && bus_dack_n));

  // R10
  settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (busy && bus_rd_n) |-> (bus_cs_n && bus_wr_n && bus_dack_n && !req_ready));

endmodule

// File: tb/hbus_access_seq_bench.sv
module hbus_access_seq_bench;

  localparam int     CLK_NS    = 10;
  localparam longint CLK_PS    = 10000;
  localparam longint STROBE_PS = 20000;
  localparam longint SETTLE_PS = 3000000;
  localparam logic [7:0] WAKE_REG = 8'h00;

  localparam int STRB   = int'((STROBE_PS + CLK_PS - 1) / CLK_PS);
  localparam int SAME   = int'((50000 + CLK_PS - 1) / CLK_PS);
  localparam int DIFF   = int'((91000 + CLK_PS - 1) / CLK_PS);
  localparam int SETTLE = int'((SETTLE_PS + CLK_PS - 1) / CLK_PS);
  localparam int NAT    = STRB + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        wake_req = 1'b0;
  logic        req_ready, rsp_valid, rsp_err, busy;
  logic [15:0] rsp_rdata, bus_wdata, bus_rdata;
  logic        bus_cs_n, bus_rd_n, bus_wr_n, bus_dack_n;
  logic [7:0]  bus_addr;

  always #(CLK_NS/2) clk = ~clk;

  hbus_access_seq #(
    .CLK_PS    (CLK_PS),
    .STROBE_PS (STROBE_PS),
    .SETTLE_PS (SETTLE_PS),
    .WAKE_REG  (WAKE_REG)
  ) u_hbus_access_seq (
    .clk, .rst_n, .req_valid, .req_addr, .req_write, .req_wdata,
    .req_ready, .rsp_valid, .rsp_err, .rsp_rdata, .wake_req, .busy,
    .bus_cs_n, .bus_rd_n, .bus_wr_n, .bus_dack_n, .bus_addr,
    .bus_wdata, .bus_rdata
  );

  // device model: read data depends on window and register
  assign bus_rdata = bus_dack_n ? {8'h5A, bus_addr} : {8'hD0, bus_addr};

  typedef struct {
    bit          err;
    bit          dma;
    bit          wr;
    logic [7:0]  addr;
    logic [15:0] wdata;
    int          gap_exp;
    int          lat_exp;
    int          present;
    string       tag;
  } exp_t;

  exp_t expq[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // monitor
  bit          prev_any = 1'b0;
  bit          started = 1'b0;
  int          st_cyc = -1000;
  int          prev_st = -1000;
  bit          ob_dma, ob_wr;
  logic [7:0]  ob_addr;
  logic [15:0] ob_wdata;
  bit          ob_cs_ok;

  always @(negedge clk) begin
    bit any;
    any = !bus_cs_n || !bus_dack_n;
    if (any && !prev_any && !busy) begin
      prev_st  = st_cyc;
      st_cyc   = cyc;
      started  = 1'b1;
      ob_dma   = !bus_dack_n;
      ob_wr    = !bus_wr_n;
      ob_addr  = bus_addr;
      ob_wdata = bus_wdata;
      ob_cs_ok = (bus_cs_n == !bus_dack_n);
    end
    prev_any = any;
    if (rsp_valid) begin
      exp_t e;
      if (expq.size() == 0) begin
        chk(0, "R4", "unexpected response", 1, 0);
      end else begin
        e = expq.pop_front();
        chk(rsp_err == e.err, e.tag, "rsp_err", rsp_err, e.err);
        if (e.err) begin
          chk(!started, "R3", "strobe on error", started, 0);
        end else begin
          chk(started, e.tag, "strobe started", started, 1);
          chk(ob_dma == e.dma && ob_cs_ok, e.tag, "window select", ob_dma, e.dma);
          chk(ob_wr == e.wr, e.tag, "direction", ob_wr, e.wr);
          chk(ob_addr == e.addr, e.tag, "bus_addr", ob_addr, e.addr);
          if (e.wr)
            chk(ob_wdata == e.wdata, e.tag, "bus_wdata", ob_wdata, e.wdata);
          else
            chk(rsp_rdata == (e.dma ? {8'hD0, e.addr} : {8'h5A, e.addr}),
                e.tag, "rsp_rdata", rsp_rdata,
                e.dma ? {8'hD0, e.addr} : {8'h5A, e.addr});
          if (e.gap_exp >= 0)
            chk(st_cyc - prev_st == e.gap_exp, e.tag, "start spacing",
                st_cyc - prev_st, e.gap_exp);
          if (e.lat_exp >= 0)
            chk(st_cyc - e.present == e.lat_exp, e.tag, "start latency",
                st_cyc - e.present, e.lat_exp);
        end
      end
      started = 1'b0;
    end
  end

  // bench model of the previous access
  bit         m_have = 1'b0;
  bit         m_wr;
  logic [8:0] m_key;

  task automatic do_req(logic [31:0] a, bit wr, logic [15:0] wd, string tag,
                        int lat = -1);
    exp_t e;
    bit   dma, ok;
    logic [8:0] key;
    ok  = (a[31:24] == 8'h00) || (a[31:24] == 8'h02);
    dma = (a[31:24] == 8'h02);
    key = {dma, a[9:2]};
    e.err = !ok; e.dma = dma; e.wr = wr; e.addr = a[9:2]; e.wdata = wd;
    e.tag = tag; e.lat_exp = lat; e.present = cyc; e.gap_exp = -1;
    if (ok && m_have) begin
      int need;
      need = ((m_wr || wr) && key != m_key) ? DIFF : SAME;
      e.gap_exp = (need > NAT) ? need : NAT;
    end
    expq.push_back(e);
    req_addr = a; req_write = wr; req_wdata = wd; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b0;
    if (ok) begin
      m_have = 1'b1; m_wr = wr; m_key = key;
    end else begin
      m_have = 1'b0;   // skip the spacing check for the next access
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int   fall_cyc, bcnt;
    bit   rdy_seen, stray;
    exp_t e;
    repeat (3) @(negedge clk);
    // R11 during reset
    chk(bus_cs_n && bus_rd_n && bus_wr_n && bus_dack_n, "R11", "strobes in reset",
        {bus_cs_n, bus_rd_n, bus_wr_n, bus_dack_n}, 4'hF);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bus_cs_n && bus_rd_n && bus_wr_n && bus_dack_n, "R11", "strobes after reset",
        {bus_cs_n, bus_rd_n, bus_wr_n, bus_dack_n}, 4'hF);
    chk(!req_ready && !rsp_valid && !busy, "R11", "ready/valid/busy after reset",
        {req_ready, rsp_valid, busy}, 0);

    do_req(32'h0000_0010, 1'b0, 16'h0,    "R8 R1", 1);   // first access, unconstrained
    do_req(32'h0000_0010, 1'b0, 16'h0,    "R5");         // same target read
    do_req(32'h0000_0010, 1'b1, 16'h1234, "R5 R4");      // same target write
    do_req(32'h0000_0020, 1'b0, 16'h0,    "R6");         // after write, new target
    do_req(32'h0000_0024, 1'b0, 16'h0,    "R7");         // read to read, new target
    do_req(32'h0000_0030, 1'b1, 16'hBEEF, "R6 R4");      // write, new target
    do_req(32'h0200_0000, 1'b1, 16'h5511, "R2 R6");      // DMA write
    do_req(32'h0200_0100, 1'b0, 16'h0,    "R2 R6");      // DMA read after write
    do_req(32'h0200_0100, 1'b0, 16'h0,    "R2 R5");      // DMA read same target
    do_req(32'h0100_0000, 1'b0, 16'h0,    "R3");
    do_req(32'hFF00_0004, 1'b1, 16'h7777, "R3");
    do_req(32'h00FF_FFFC, 1'b0, 16'h0,    "R1");         // top of register window

    // wake-up
    @(negedge clk);
    wake_req = 1'b1;
    do @(negedge clk); while (!busy);
    wake_req = 1'b0;
    chk(!bus_cs_n && !bus_rd_n && bus_wr_n && bus_dack_n, "R9", "wake strobe pins",
        {bus_cs_n, bus_rd_n, bus_wr_n, bus_dack_n}, 4'b0011);
    chk(bus_addr == WAKE_REG, "R9", "wake address", bus_addr, WAKE_REG);
    e.err = 0; e.dma = 0; e.wr = 0; e.addr = 8'h11; e.wdata = 0;
    e.gap_exp = -1; e.lat_exp = -1; e.present = cyc; e.tag = "R10";
    expq.push_back(e);
    req_addr = 32'h0000_0044; req_write = 1'b0; req_valid = 1'b1;
    bcnt = 0; rdy_seen = 0; stray = 0;
    while (busy) begin
      bcnt++;
      if (req_ready) rdy_seen = 1;
      if (!bus_wr_n || !bus_dack_n || (bcnt > STRB && !bus_rd_n)) stray = 1;
      @(negedge clk);
    end
    fall_cyc = cyc;
    chk(bcnt == STRB + SETTLE, "R9", "busy length", bcnt, STRB + SETTLE);
    chk(!rdy_seen, "R10", "ready while busy", rdy_seen, 0);
    chk(!stray, "R10", "strobe while settling", stray, 0);
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b0;
    chk(st_cyc == fall_cyc + 1, "R10", "held request start", st_cyc, fall_cyc + 1);
    m_have = 1'b0;
    do_req(32'h0000_0044, 1'b1, 16'hA0A0, "R4");

    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R4", "responses outstanding", expq.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule